// File: doc/BRIEF.md
# Linear Chirp Direct Digital Synthesizer

This block is a numerically controlled oscillator whose tuning word is driven by a built-in linear ramp engine. It is used to produce frequency sweeps (chirps) for continuous-wave radar front ends. A 32-bit phase accumulator adds the current tuning word on every accepted cycle. The top 12 phase bits select a point on a sine curve. The resulting signed 14-bit sample leaves the block on a valid/ready stream toward a DAC. The output frequency is the tuning word divided by 2^32, times the sample rate.

Software programs four configuration words through a simple write port: a low limit, a high limit, a step delta and a dwell word. The dwell word holds a dwell count in bits 15:0 and a restart-mode flag in bit 31. Writes go to staging registers. The ramp engine copies them into its working set only when a sweep begins, so a sweep in flight is never disturbed. A level-sensitive run input starts and stops sweeps.

The sweep begins at the low limit. The tuning word stays at each value for the dwell count, then moves up by the step. When the next value would reach or pass the high limit, the tuning word is clamped to that limit and the done flag rises. The sweep then either parks there or, in restart mode, begins again after one more dwell. The accumulator itself is never reloaded, so every frequency change is phase-continuous. A coarse stepped sweep is the same mechanism with a large step and a long dwell.

The output stream obeys normal back-pressure rules. Once `smp_valid` is high it stays high. While `smp_valid` is high and `smp_ready` is low, the block is frozen: the sample, the phase, the tuning word and the dwell counter all hold. Every other cycle is an accepted cycle, in which all state advances once.

Top module: `chirp_dds`

## Requirements
- R1: On every accepted cycle, `phase_out` becomes its previous value plus the previous `ftw_out`, modulo 2^32. No ramp event (step, clamp, restart, start or stop) ever reloads it.
- R2: The sample presented after an accepted cycle is the sine value of the top 12 bits of the phase held before that cycle. The sample is round(8191*sin(pi*(j+0.5)/2048)), where j is the low 10 address bits in quadrants 0 and 2, and 1023 minus those bits in quadrants 1 and 3. The value is negated in quadrants 2 and 3. The quadrant is address bits 11:10.
- R3: While reset is low, `ftw_out`, `phase_out`, `smp_data`, `smp_valid` and `sweep_done` are all zero.
- R4: The sweep starts on the first accepted cycle in which run is high while the engine is idle. From the following cycle, `ftw_out` equals the low limit (address 0), holds each value for the dwell count (address 3, bits 15:0), and then rises by exactly the step (address 2).
- R5: A dwell count of zero behaves as a dwell of one cycle.
- R6: When the current word plus the step, formed as a 33-bit sum, is greater than or equal to the high limit (address 1), the next value is the high limit and `sweep_done` goes high. This includes the case where the sum carries past 2^32.
- R7: With bit 31 of the dwell word clear (hold mode), the tuning word stays at the high limit and `sweep_done` stays high until a new start.
- R8: With bit 31 set (restart mode), after one dwell at the high limit a new sweep begins from the low limit and `sweep_done` falls.
- R9: Configuration writes made during a sweep leave that sweep unchanged and take effect at the next sweep start.
- R10: Dropping run freezes `ftw_out` while the phase keeps advancing. Raising run again starts a new sweep from the low limit with `sweep_done` low.
- R11: While `smp_valid` is high and `smp_ready` is low, `smp_data`, `phase_out` and `ftw_out` hold their values.
- R12: `smp_valid` rises after the first clock after reset and never falls until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Word select: 0 low limit, 1 high limit, 2 step, 3 dwell/mode |
| cfg_wdata | input | 32 | Configuration write data |
| sweep_run | input | 1 | Level: high runs sweeps, low stops |
| smp_data | output | 14 | Signed sine sample |
| smp_valid | output | 1 | Sample stream valid |
| smp_ready | input | 1 | Sample stream ready (back-pressure) |
| ftw_out | output | 32 | Tuning word now in use |
| phase_out | output | 32 | Phase accumulator value |
| sweep_done | output | 1 | Tuning word clamped at the high limit |

## Verification
The hardest case to reach from the ports is the sweep boundary in restart mode combined with a staging write in flight. Here the old sweep must finish on its captured step while the next sweep picks up the new one. The stimulus writes a new step a few cycles into the first sweep. The bench then follows the word through the clamp, the extra dwell at the limit, and into a second sweep that must have the new step count. The 33-bit carry of the clamp compare is reached by placing the limits within one step of 2^32. The sine table is covered in full by holding the tuning word at exactly one address per cycle for more than 4096 cycles.

// File: rtl/chirp_pkg.sv
package chirp_pkg;
  typedef enum logic [1:0] {
    CFG_LOWER = 2'd0,
    CFG_UPPER = 2'd1,
    CFG_STEP  = 2'd2,
    CFG_DWELL = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/chirp_cfg.sv
module chirp_cfg #(
  parameter int FTW_W   = 32,
  parameter int DWELL_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [1:0]         addr,
  input  logic [FTW_W-1:0]   wdata,
  output logic [FTW_W-1:0]   stg_lower,
  output logic [FTW_W-1:0]   stg_upper,
  output logic [FTW_W-1:0]   stg_step,
  output logic [DWELL_W-1:0] stg_dwell,
  output logic               stg_restart
);
  import chirp_pkg::*;

  cfg_sel_e sel;
  assign sel = cfg_sel_e'(addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_lower   <= '0;
      stg_upper   <= '0;
      stg_step    <= '0;
      stg_dwell   <= '0;
      stg_restart <= 1'b0;
    end else if (we) begin
      unique case (sel)
        CFG_LOWER: stg_lower <= wdata;
        CFG_UPPER: stg_upper <= wdata;
        CFG_STEP:  stg_step  <= wdata;
        CFG_DWELL: begin
          stg_dwell   <= wdata[DWELL_W-1:0];
          stg_restart <= wdata[FTW_W-1];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/chirp_ramp.sv
module chirp_ramp #(
  parameter int FTW_W   = 32,
  parameter int DWELL_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               adv,
  input  logic               run,
  input  logic [FTW_W-1:0]   stg_lower,
  input  logic [FTW_W-1:0]   stg_upper,
  input  logic [FTW_W-1:0]   stg_step,
  input  logic [DWELL_W-1:0] stg_dwell,
  input  logic               stg_restart,
  output logic [FTW_W-1:0]   ftw,
  output logic               done
);
  localparam logic [DWELL_W-1:0] ONE = DWELL_W'(1);

  logic               running;
  logic [FTW_W-1:0]   up_a, st_a;
  logic [DWELL_W-1:0] dw_a, cnt;
  logic               rs_a;
  logic [FTW_W:0]     next_sum;
  logic               hit, last, begin_sweep;

  assign next_sum    = {1'b0, ftw} + {1'b0, st_a};
  assign hit         = next_sum >= {1'b0, up_a};
  assign last        = (cnt == dw_a - ONE);
  assign begin_sweep = run && (!running || (done && rs_a && last));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      up_a    <= '0;
      st_a    <= '0;
      dw_a    <= ONE;
      rs_a    <= 1'b0;
      cnt     <= '0;
      ftw     <= '0;
      done    <= 1'b0;
    end else if (adv) begin
      if (!run) begin
        running <= 1'b0;
      end else if (begin_sweep) begin
        running <= 1'b1;
        up_a    <= stg_upper;
        st_a    <= stg_step;
        dw_a    <= (stg_dwell == '0) ? ONE : stg_dwell;
        rs_a    <= stg_restart;
        ftw     <= stg_lower;
        cnt     <= '0;
        done    <= 1'b0;
      end else if (last) begin
        cnt <= '0;
        if (!done) begin
          if (hit) begin
            ftw  <= up_a;
            done <= 1'b1;
          end else begin
            ftw <= next_sum[FTW_W-1:0];
          end
        end
      end else begin
        cnt <= cnt + ONE;
      end
    end
  end

  AST_DONE_AT_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ftw == up_a); // R6
  AST_STEP_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && run && running && !done && last && !hit) |=> ftw == $past(ftw + st_a)); // R4
  AST_DWELL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && run && running && !last) |=> $stable(ftw)); // R4
  AST_RAMP_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(ftw)); // R11
endmodule

// File: rtl/chirp_phase.sv
module chirp_phase #(
  parameter int FTW_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [FTW_W-1:0] inc,
  output logic [FTW_W-1:0] acc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc <= '0;
    else if (adv) acc <= acc + inc;
  end

  AST_PHASE_INC: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> acc == $past(acc + inc)); // R1
  AST_PHASE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(acc)); // R11
endmodule

// File: rtl/chirp_sine.sv
module chirp_sine #(
  parameter int ADDR_W = 12,
  parameter int SAMP_W = 14
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     ready,
  output logic                     adv,
  output logic signed [SAMP_W-1:0] data,
  output logic                     valid
);
  localparam int  QBITS = ADDR_W - 2;
  localparam int  QN    = 1 << QBITS;
  localparam real AMP   = real'((1 << (SAMP_W - 1)) - 1);
  localparam real PI    = 3.14159265358979323846;

  function automatic int qval(input int q);
    real a;
    a = AMP * $sin(PI * (real'(q) + 0.5) / (2.0 * real'(QN)));
    return $rtoi(a + 0.5);
  endfunction

  logic [SAMP_W-2:0] qrom [QN];

  for (genvar q = 0; q < QN; q++) begin : g_qrom
    localparam int QV = qval(q);
    assign qrom[q] = QV[SAMP_W-2:0];
  end

  logic [1:0]              quad;
  logic [QBITS-1:0]        idx;
  logic [SAMP_W-2:0]       mag;
  logic signed [SAMP_W-1:0] val;

  always_comb begin
    quad = addr[ADDR_W-1:ADDR_W-2];
    idx  = quad[0] ? ~addr[QBITS-1:0] : addr[QBITS-1:0];
    mag  = qrom[idx];
    val  = quad[1] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
  end

  assign adv = !valid || ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data  <= '0;
      valid <= 1'b0;
    end else if (adv) begin
      data  <= val;
      valid <= 1'b1;
    end
  end

  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> valid); // R12
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> $stable(data)); // R11
endmodule

// File: rtl/chirp_dds.sv
module chirp_dds #(
  parameter int FTW_W   = 32,
  parameter int DWELL_W = 16,
  parameter int ADDR_W  = 12,
  parameter int SAMP_W  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [FTW_W-1:0]  cfg_wdata,
  input  logic              sweep_run,
  output logic [SAMP_W-1:0] smp_data,
  output logic              smp_valid,
  input  logic              smp_ready,
  output logic [FTW_W-1:0]  ftw_out,
  output logic [FTW_W-1:0]  phase_out,
  output logic              sweep_done
);
  localparam int ADDR_LSB = FTW_W - ADDR_W;

  logic [FTW_W-1:0]   stg_lower, stg_upper, stg_step;
  logic [DWELL_W-1:0] stg_dwell;
  logic               stg_restart;
  logic               adv;
  logic signed [SAMP_W-1:0] sample;

  chirp_cfg #(.FTW_W(FTW_W), .DWELL_W(DWELL_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .stg_lower(stg_lower), .stg_upper(stg_upper), .stg_step(stg_step),
    .stg_dwell(stg_dwell), .stg_restart(stg_restart)
  );

  chirp_ramp #(.FTW_W(FTW_W), .DWELL_W(DWELL_W)) u_ramp (
    .clk(clk), .rst_n(rst_n), .adv(adv), .run(sweep_run),
    .stg_lower(stg_lower), .stg_upper(stg_upper), .stg_step(stg_step),
    .stg_dwell(stg_dwell), .stg_restart(stg_restart),
    .ftw(ftw_out), .done(sweep_done)
  );

  chirp_phase #(.FTW_W(FTW_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .adv(adv), .inc(ftw_out), .acc(phase_out)
  );

  chirp_sine #(.ADDR_W(ADDR_W), .SAMP_W(SAMP_W)) u_sine (
    .clk(clk), .rst_n(rst_n), .addr(phase_out[FTW_W-1:ADDR_LSB]),
    .ready(smp_ready), .adv(adv), .data(sample), .valid(smp_valid)
  );

  assign smp_data = sample;
endmodule

// File: tb/chirp_dds_test.sv
module chirp_dds_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = 2'd0;
  logic [31:0] cfg_wdata = 32'd0;
  logic        sweep_run = 1'b0;
  logic        smp_ready = 1'b1;
  logic [13:0] smp_data;
  logic        smp_valid;
  logic [31:0] ftw_out;
  logic [31:0] phase_out;
  logic        sweep_done;

  int checks = 0;
  int errors = 0;
  bit track = 0;
  logic [31:0] prev_phase, prev_ftw;

  always #2.5 clk = ~clk;

  chirp_dds uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .sweep_run(sweep_run), .smp_data(smp_data),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .ftw_out(ftw_out),
    .phase_out(phase_out), .sweep_done(sweep_done)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_sine(input int a);
    int q, i, idx, m;
    real r;
    q = a >> 10;
    i = a & 1023;
    idx = (q & 1) ? 1023 - i : i;
    r = 8191.0 * $sin(3.14159265358979323846 * (real'(idx) + 0.5) / 2048.0);
    m = $rtoi(r + 0.5);
    return (q & 2) ? -m : m;
  endfunction

  task automatic step_clk();
    @(negedge clk);
    if (track) begin
      chk(phase_out == prev_phase + prev_ftw, "R1 phase increment", phase_out,
          longint'(prev_phase + prev_ftw));
      chk(int'($signed(smp_data)) == exp_sine(int'(prev_phase[31:20])), "R2 sine sample",
          int'($signed(smp_data)), exp_sine(int'(prev_phase[31:20])));
      prev_phase = phase_out;
      prev_ftw   = ftw_out;
    end
  endtask

  task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    step_clk();
    cfg_we = 1'b0;
  endtask

  function automatic longint kmax_of(input longint lo, input longint hi, input longint st);
    longint k;
    if (st == 0) return 64'h7fff_ffff_ffff;
    k = 1;
    while (lo + k * st < hi) k++;
    return k;
  endfunction

  // expected word and done flag for one sweep, index j from the first word
  task automatic exp_one(input longint lo, input longint hi, input longint st, input int d,
                         input int j, output longint f, output bit dn);
    longint k, km;
    k  = j / d;
    km = kmax_of(lo, hi, st);
    if (k < km) begin f = lo + k * st; dn = 0; end
    else begin f = hi; dn = 1; end
  endtask

  task automatic run_sweep(input longint lo, input longint hi, input longint st, input int dw,
                           input bit rs, input int n, input int chg_at, input longint st2,
                           input string req);
    int deff;
    longint f, cur_st;
    bit dn;
    int t;
    longint per;
    deff = (dw == 0) ? 1 : dw;
    sweep_run = 1'b0;
    step_clk();
    cfg_write(2'd0, lo[31:0]);
    cfg_write(2'd1, hi[31:0]);
    cfg_write(2'd2, st[31:0]);
    cfg_write(2'd3, {rs, 15'd0, 16'(dw)});
    sweep_run = 1'b1;
    for (int j = 0; j < n; j++) begin
      step_clk();
      t = j;
      cur_st = st;
      if (rs) begin
        per = (kmax_of(lo, hi, cur_st) + 1) * deff;
        while (t >= per) begin
          t = t - int'(per);
          if (chg_at >= 0) cur_st = st2;
          per = (kmax_of(lo, hi, cur_st) + 1) * deff;
        end
      end
      exp_one(lo, hi, cur_st, deff, t, f, dn);
      chk(longint'(ftw_out) == f, req, ftw_out, f);
      chk(sweep_done == dn, {req, " done flag"}, sweep_done, dn);
      if (j == chg_at) begin
        cfg_we = 1'b1; cfg_addr = 2'd2; cfg_wdata = st2[31:0];
      end
      if (j == chg_at + 1) cfg_we = 1'b0;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] hd, hp, hf;
    // R3 / R12: reset state
    repeat (3) @(negedge clk);
    chk(ftw_out == 0 && phase_out == 0 && sweep_done == 0, "R3 reset outputs", ftw_out, 0);
    chk(smp_data == 0, "R3 reset sample", smp_data, 0);
    chk(smp_valid == 0, "R12 valid low in reset", smp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(smp_valid == 1, "R12 valid after first clock", smp_valid, 1);
    prev_phase = phase_out;
    prev_ftw   = ftw_out;
    track = 1;

    // R2 exhaustive table: one address per cycle
    run_sweep(64'h0010_0000, 64'hFFFF_FFFF, 0, 1, 0, 4200, -1, 0, "R4 constant word");
    // R1 odd tuning word
    run_sweep(64'h0123_4567, 64'hFFFF_FFFF, 0, 1, 0, 300, -1, 0, "R4 odd word");
    // R4 R6 R7 hold-mode sweep
    run_sweep(1000, 1000 + 1600, 300, 3, 0, 40, -1, 0, "R7 hold sweep");
    // R8 R9 restart with a step change mid-sweep
    run_sweep(5000, 7800, 700, 4, 1, 50, 3, 1400, "R9 restart shadow");
    // R6 33-bit carry clamp
    run_sweep(64'hF000_0000, 64'hFFFF_FFF0, 64'h0800_0000, 2, 0, 12, -1, 0, "R6 carry clamp");
    // R5 zero dwell
    run_sweep(10, 25, 5, 0, 0, 8, -1, 0, "R5 zero dwell");
    // R4 coarse stepped mode
    run_sweep(536870912, 536870912 + 42949673, 42949673, 1000, 0, 2500, -1, 0, "R4 coarse step");

    // R10 stop freezes the word, phase still advances (tracked)
    sweep_run = 1'b0;
    for (int i = 0; i < 6; i++) begin
      step_clk();
      chk(ftw_out == 32'd579820585, "R10 word frozen", ftw_out, 579820585);
    end
    sweep_run = 1'b1;
    step_clk();
    chk(ftw_out == 32'd536870912, "R10 restart at low limit", ftw_out, 536870912);
    chk(sweep_done == 0, "R10 done cleared", sweep_done, 0);

    // R11 back-pressure
    track = 0;
    hd = 32'(smp_data); hp = phase_out; hf = ftw_out;
    smp_ready = 1'b0;
    for (int i = 0; i < 6; i++) begin
      step_clk();
      chk(32'(smp_data) == hd, "R11 sample held", smp_data, hd);
      chk(phase_out == hp, "R11 phase held", phase_out, hp);
      chk(ftw_out == hf, "R11 word held", ftw_out, hf);
      chk(smp_valid == 1, "R12 valid stays high", smp_valid, 1);
    end
    smp_ready = 1'b1;
    track = 1;
    repeat (5) step_clk();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule